// File: doc/BRIEF.md
# Thresholded Event Counter with Edge Filter

This block is one counting slice of a performance-monitoring unit. Every clock it sees a 4-bit weighted event value (lines worth 1, 2, 4 and 8, so 0 to 15) and a current-privilege bit. From these it decides what to add to a wide wrapping counter. In plain mode the raw value is added. In compare mode a threshold test reduces the value to a 0/1 increment, and an optional rising-edge stage can reduce that further to one count per false-to-true change.

Configuration is one write-only word. The counter can be preset through a separate load port. On a wrap the slice emits a one-cycle overflow pulse. That pulse can drive the cascade-start input of a partner slice. If enabled, the wrap also sets a sticky interrupt request that stays set until a clear input is pulsed. A slice configured to wait for its partner stays idle until the partner's overflow pulse arrives.

Top module: `evt_thresh_counter`

## Requirements
- R1: After reset the count is 0, and `ovf_pulse` and `irq_req` are low.
- R2: With the counter enabled and compare clear, the 4-bit event value, whose lines weigh 1, 2, 4 and 8, is added to the count on every clock edge.
- R3: With compare set and complement clear, the count rises by exactly 1 when the event value is greater than the threshold, and by 0 otherwise.
- R4: With compare and complement both set, the count rises by exactly 1 when the event value is less than or equal to the threshold, and by 0 otherwise.
- R5: With compare and edge both set, a count is made only when the threshold result is true in this cycle and was false in the previous cycle. The remembered result is 0 after reset and while the slice is inactive, so a condition that is already true in the first active cycle counts. The edge flag has no effect while compare is clear.
- R6: An event is qualified by the user flag when `priv_sup` is 0 and by the supervisor flag when `priv_sup` is 1. A disqualified cycle adds 0 and counts as a false threshold result for the edge stage.
- R7: With enable clear, the count holds its value.
- R8: The count wraps modulo 2^40. `ovf_pulse` is high for the single cycle that follows an addition which carried out of the top bit.
- R9: An overflow with the interrupt enable set raises `irq_req` together with `ovf_pulse`. The request stays high until `irq_clr` is pulsed. A new overflow in the same cycle as a clear wins.
- R10: A configuration write with the cascade-wait flag set keeps the slice idle. A pulse on `partner_ovf` releases it, and counting starts from the next cycle. A write with the flag clear also ends the wait.
- R11: `cnt_we` loads `cnt_wdata` into the count. A load takes priority over that cycle's increment and never signals an overflow.
- R12: Configuration word layout: bit 0 enable, bit 1 compare, bit 2 complement, bits 6:3 threshold, bit 7 edge, bit 8 user qualify, bit 9 supervisor qualify, bit 10 interrupt enable, bit 11 cascade wait. A written word takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration word (layout in R12) |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | 40 | Counter load value |
| evt_in | input | 4 | Weighted event value for this cycle |
| priv_sup | input | 1 | Current privilege: 1 supervisor, 0 user |
| partner_ovf | input | 1 | Overflow pulse from the partner slice (cascade start) |
| irq_clr | input | 1 | Clears the interrupt request |
| cnt_value | output | 40 | Current count |
| ovf_pulse | output | 1 | One-cycle wrap indication; also the cascade output |
| irq_req | output | 1 | Sticky overflow interrupt request |

## Verification
Every input sampled at a clock edge shows its effect on `cnt_value`, `ovf_pulse` and `irq_req` directly after that same edge. A configuration, release or load written at one edge governs the increment at the following edge. The bench drives inputs on the falling edge and advances its own model by one step per cycle. On the next falling edge it compares all three outputs against that model, so every result is checked exactly one register stage after its stimulus.

// File: rtl/evc_pkg.sv
package evc_pkg;

  localparam int EVT_W = 4;

  // Field order, LSB first: en, cmp, cmpl, thr, edg, usr_en, sup_en, irq_en, cas_wait (R12)
  typedef struct packed {
    logic             cas_wait;
    logic             irq_en;
    logic             sup_en;
    logic             usr_en;
    logic             edg;
    logic [EVT_W-1:0] thr;
    logic             cmpl;
    logic             cmp;
    logic             en;
  } evc_cfg_t;

  localparam int CFG_W = $bits(evc_cfg_t);

endpackage

// File: rtl/evc_cfg.sv
module evc_cfg
  import evc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             partner_ovf,
  output evc_cfg_t         cfg,
  output logic             active
);

  evc_cfg_t cfg_q, cfg_d;
  logic     wait_q, wait_d;

  always_comb begin
    cfg_d  = cfg_q;
    wait_d = wait_q;
    if (cfg_we) begin
      cfg_d  = evc_cfg_t'(cfg_wdata);
      wait_d = cfg_d.cas_wait;
    end else if (wait_q && partner_ovf) begin
      wait_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_d;
      wait_q <= wait_d;
    end
  end

  assign cfg    = cfg_q;
  assign active = cfg_q.en && !wait_q;

  // R10: a partner overflow releases a waiting slice
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && partner_ovf && !cfg_we) |=> active == cfg_q.en);

endmodule

// File: rtl/evc_filter.sv
module evc_filter #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             cmp,
  input  logic             cmpl,
  input  logic             edg,
  input  logic [EVT_W-1:0] thr,
  input  logic             usr_en,
  input  logic             sup_en,
  input  logic             priv_sup,
  input  logic [EVT_W-1:0] evt_in,
  output logic [EVT_W-1:0] inc
);

  logic qual, hit, prev_q, prev_d;

  always_comb begin
    qual = priv_sup ? sup_en : usr_en;
    hit  = qual && (cmpl ? (evt_in <= thr) : (evt_in > thr));
    inc  = '0;
    if (active && qual) begin
      if (!cmp)      inc = evt_in;
      else if (edg)  inc = EVT_W'(hit && !prev_q);
      else           inc = EVT_W'(hit);
    end
    prev_d = active ? hit : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R3/R4: compare mode never adds more than one
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    cmp |-> inc <= EVT_W'(1));
  // R5: two edge counts never come back to back
  a_r5_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmp && edg && inc != '0) |=> (!(active && cmp && edg) || inc == '0));
  // R7/R10: inactive slice contributes nothing
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> inc == '0);

endmodule

// File: rtl/evc_accum.sv
module evc_accum #(
  parameter int CNT_W = 40,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_pulse,
  output logic             irq_req
);

  localparam int PAD_W = CNT_W + 1 - EVT_W;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce, ovf_d, irq_d;

  always_comb begin
    sum    = {1'b0, cnt} + {{PAD_W{1'b0}}, inc};
    cnt_ce = load || (inc != '0);
    cnt_d  = load ? load_val : sum[CNT_W-1:0];
    ovf_d  = !load && sum[CNT_W];
    if (ovf_d && irq_en) irq_d = 1'b1;
    else if (irq_clr)    irq_d = 1'b0;
    else                 irq_d = irq_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      ovf_pulse <= 1'b0;
      irq_req   <= 1'b0;
    end else begin
      if (cnt_ce) cnt <= cnt_d;
      ovf_pulse <= ovf_d;
      irq_req   <= irq_d;
    end
  end

  // R11: a load lands as written
  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val) && !ovf_pulse));
  // R7: no increment and no load keeps the count
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && inc == '0) |=> $stable(cnt));
  // R8: a wrap pulse lasts one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);
  // R9: request holds until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_clr) |=> irq_req);

endmodule

// File: rtl/evt_thresh_counter.sv
module evt_thresh_counter
  import evc_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [EVT_W-1:0] evt_in,
  input  logic             priv_sup,
  input  logic             partner_ovf,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt_value,
  output logic             ovf_pulse,
  output logic             irq_req
);

  evc_cfg_t         cfg;
  logic             active;
  logic [EVT_W-1:0] inc;

  evc_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .partner_ovf (partner_ovf),
    .cfg         (cfg),
    .active      (active)
  );

  evc_filter #(.EVT_W(EVT_W)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .cmp      (cfg.cmp),
    .cmpl     (cfg.cmpl),
    .edg      (cfg.edg),
    .thr      (cfg.thr),
    .usr_en   (cfg.usr_en),
    .sup_en   (cfg.sup_en),
    .priv_sup (priv_sup),
    .evt_in   (evt_in),
    .inc      (inc)
  );

  evc_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (inc),
    .load      (cnt_we),
    .load_val  (cnt_wdata),
    .irq_en    (cfg.irq_en),
    .irq_clr   (irq_clr),
    .cnt       (cnt_value),
    .ovf_pulse (ovf_pulse),
    .irq_req   (irq_req)
  );

  // R9: an overflow with interrupts on raises the request at once
  a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && $past(cfg.irq_en)) |-> irq_req);
  // R8: a wrap leaves a small count behind
  a_r8_wrap_small: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> cnt_value < CNT_W'(16));

endmodule

// File: tb/evt_thresh_counter_test.sv
`timescale 1ns/1ps
module evt_thresh_counter_test;

  localparam int CW = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [11:0]   cfg_wdata;
  logic          cnt_we;
  logic [CW-1:0] cnt_wdata;
  logic [3:0]    evt_in;
  logic          priv_sup, partner_ovf, irq_clr;
  logic [CW-1:0] cnt_value;
  logic          ovf_pulse, irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [11:0]   m_cfg;
  logic          m_wait, m_prev, m_ovf, m_irq;
  logic [CW-1:0] m_cnt;
  string         m_tag;

  always #2.5 clk = ~clk;

  evt_thresh_counter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .evt_in(evt_in),
    .priv_sup(priv_sup), .partner_ovf(partner_ovf), .irq_clr(irq_clr),
    .cnt_value(cnt_value), .ovf_pulse(ovf_pulse), .irq_req(irq_req)
  );

  // config word builder, R12 layout
  function automatic logic [11:0] cw(input bit en, input bit cmp, input bit cmpl,
                                     input logic [3:0] thr, input bit edg, input bit usr,
                                     input bit sup, input bit irq, input bit cas);
    return {cas, irq, sup, usr, edg, thr, cmpl, cmp, en};
  endfunction

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(m_tag, cnt_value, m_cnt);
    chk("R8 ovf_pulse", CW'(ovf_pulse), CW'(m_ovf));
    chk("R9 irq_req", CW'(irq_req), CW'(m_irq));
  endtask

  // advance the model by one clock edge using the inputs now driven
  task automatic step();
    logic act, qual, hit, carry;
    logic [3:0] inc;
    logic [CW:0] sum;
    act  = m_cfg[0] && !m_wait;
    qual = priv_sup ? m_cfg[9] : m_cfg[8];
    hit  = qual && (m_cfg[2] ? (evt_in <= m_cfg[6:3]) : (evt_in > m_cfg[6:3]));
    inc  = 4'd0;
    if (act && qual) begin
      if (!m_cfg[1])     inc = evt_in;
      else if (m_cfg[7]) inc = {3'b0, hit && !m_prev};
      else               inc = {3'b0, hit};
    end
    if (cnt_we)          m_tag = "R11 load";
    else if (m_wait)     m_tag = "R10 cascade wait";
    else if (!m_cfg[0])  m_tag = "R7 disabled";
    else if (!qual)      m_tag = "R6 privilege";
    else if (!m_cfg[1])  m_tag = "R2 raw R12";
    else if (m_cfg[7])   m_tag = "R5 edge R12";
    else if (m_cfg[2])   m_tag = "R4 le R12";
    else                 m_tag = "R3 gt R12";
    sum   = {1'b0, m_cnt} + {37'b0, inc};
    carry = sum[CW];
    m_prev = act ? hit : 1'b0;
    m_ovf  = !cnt_we && carry;
    m_cnt  = cnt_we ? cnt_wdata : sum[CW-1:0];
    if (m_ovf && m_cfg[10]) m_irq = 1'b1;
    else if (irq_clr)       m_irq = 1'b0;
    if (cfg_we) begin
      m_cfg  = cfg_wdata;
      m_wait = cfg_wdata[11];
    end else if (m_wait && partner_ovf) begin
      m_wait = 1'b0;
    end
  endtask

  task automatic cyc(input bit cwe, input logic [11:0] cwd, input bit lwe,
                     input logic [CW-1:0] lwd, input logic [3:0] ev, input bit pv,
                     input bit po, input bit ic);
    @(negedge clk);
    compare();
    cfg_we = cwe; cfg_wdata = cwd; cnt_we = lwe; cnt_wdata = lwd;
    evt_in = ev; priv_sup = pv; partner_ovf = po; irq_clr = ic;
    step();
  endtask

  task automatic ev(input logic [3:0] e, input bit pv);
    cyc(0, 12'h0, 0, '0, e, pv, 0, 0);
  endtask

  task automatic setcfg(input logic [11:0] c);
    cyc(1, c, 0, '0, 4'd0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = '0; cnt_we = 0; cnt_wdata = '0;
    evt_in = '0; priv_sup = 0; partner_ovf = 0; irq_clr = 0;
    m_cfg = '0; m_wait = 0; m_prev = 0; m_ovf = 0; m_irq = 0; m_cnt = '0;
    m_tag = "R1 reset";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1 reset count", cnt_value, '0);
    chk("R1 reset ovf", CW'(ovf_pulse), '0);
    chk("R1 reset irq", CW'(irq_req), '0);
    ev(4'd15, 0);                      // disabled: R7

    // R2: raw weighted add
    setcfg(cw(1,0,0,4'd0,0,1,1,0,0));
    ev(4'd3,0); ev(4'd15,1); ev(4'd0,0); ev(4'd9,0);
    ev(4'd1,0); ev(4'd2,0); ev(4'd4,0); ev(4'd8,0);
    // R5: edge flag ignored without compare
    setcfg(cw(1,0,0,4'd6,1,1,1,0,0));
    ev(4'd9,0); ev(4'd9,0);
    // R3: greater-than threshold 6
    setcfg(cw(1,1,0,4'd6,0,1,1,0,0));
    ev(4'd7,0); ev(4'd6,0); ev(4'd15,0); ev(4'd0,0);
    // R4: less-or-equal threshold 6
    setcfg(cw(1,1,1,4'd6,0,1,1,0,0));
    ev(4'd6,0); ev(4'd7,0); ev(4'd0,0);
    // R5: rising edge only
    setcfg(cw(1,1,0,4'd6,1,1,1,0,0));
    ev(4'd9,0); ev(4'd9,0); ev(4'd0,0); ev(4'd9,0); ev(4'd9,0);
    // R6: supervisor cycle disqualified, breaks the edge run
    setcfg(cw(1,1,0,4'd6,1,1,0,0,0));
    ev(4'd9,0); ev(4'd9,1); ev(4'd9,0); ev(4'd15,1);
    setcfg(cw(1,0,0,4'd0,0,1,0,0,0));
    ev(4'd15,1); ev(4'd15,0);
    // R7: disabled holds, then R5 condition true at enable counts
    setcfg(cw(0,1,0,4'd6,1,1,1,0,0));
    ev(4'd15,0); ev(4'd15,0);
    setcfg(cw(1,1,0,4'd6,1,1,1,0,0));
    ev(4'd15,0); ev(4'd15,0);
    // R8/R9/R11: wrap with interrupt, load priority
    setcfg(cw(1,0,0,4'd0,0,1,1,1,0));
    cyc(0, 12'h0, 1, {CW{1'b1}} - CW'(2), 4'd15, 0, 0, 0);
    ev(4'd5,0); ev(4'd0,0); ev(4'd0,0);
    cyc(0, 12'h0, 0, '0, 4'd0, 0, 0, 1);
    ev(4'd0,0);
    cyc(0, 12'h0, 1, {CW{1'b1}}, 4'd0, 0, 0, 0);
    cyc(0, 12'h0, 0, '0, 4'd1, 0, 0, 1);  // overflow wins over clear
    ev(4'd0,0);
    cyc(0, 12'h0, 0, '0, 4'd0, 0, 0, 1);
    // R10: cascade wait and release
    setcfg(cw(1,0,0,4'd0,0,1,1,0,1));
    ev(4'd5,0); ev(4'd5,0);
    cyc(0, 12'h0, 0, '0, 4'd5, 0, 1, 0);
    ev(4'd5,0); ev(4'd5,0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] c;
      bit cwe, lwe;
      c    = 12'($urandom);
      c[0] = ($urandom % 8) != 0;
      c[11] = ($urandom % 10) == 0;
      cwe  = ($urandom % 40) == 0;
      lwe  = ($urandom % 60) == 0;
      cyc(cwe, c, lwe, {CW{1'b1}} - CW'($urandom % 40), 4'($urandom),
          1'($urandom), ($urandom % 12) == 0, ($urandom % 15) == 0);
    end
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule